// File: doc/BRIEF.md
# Three-Input Programmable Logic Cell

This block is one programmable logic element of a small port-level logic fabric. It has three trigger inputs and an 8-bit truth table. Each trigger is picked by a 4-bit selector from a fixed pool of sixteen sources. Eight of those sources are feedback lines from the eight cells of the array. The other eight are the four chip-side and four pad-side signals that belong to this cell's half of the port. The three chosen triggers form a 3-bit index into the truth table, and the selected table bit becomes the cell's result.

A 2-bit mode field sets how that result reaches the output. In combinational mode the result goes straight out. In the second mode the third trigger is sampled before it enters the index. In the third mode the result is registered. In the fourth mode the first two triggers act as a set/clear pair on a held state bit. All internal flip-flops run on one fabric clock and clear on a synchronous fabric reset. They freeze while the cell is disabled.

A cell with a single source is built by pointing all three selectors at the same signal. The table is then programmed so that it only reacts to the all-zero and all-one indices.

Top module: `lut3_cell`

## Requirements
- R1: While `rst` is high at a rising clock edge, every internal flip-flop (sampled third trigger, registered result, set/clear state) becomes 0. In mode 2 the output therefore reads 0 right after reset, whatever the table holds.
- R2: In mode 0 (combinational) the output is `table_bits[{t2,t1,t0}]` with no clock delay, where t0, t1 and t2 are the signals chosen by `sel_tr0`, `sel_tr1` and `sel_tr2`. Index 000 selects bit 0 and index 111 selects bit 7.
- R3: Selector codes 0 to 7 choose `cell_fb[0]` to `cell_fb[7]`, and bits of `cell_fb` that are not selected have no effect on the output.
- R4: Selector codes 8 to 11 choose chip-side signals and codes 12 to 15 choose pad-side signals of the cell's half. With `HALF`=0, codes 8+k and 12+k pick `chip_sig[k]` and `pad_sig[k]`. With `HALF`=1 they pick `chip_sig[4+k]` and `pad_sig[4+k]`.
- R5: In mode 1 the third trigger is sampled on each enabled rising clock edge, and the index is `{sampled t2, t1, t0}`. A change on t2 reaches the output one edge later, while changes on t0 and t1 reach it at once.
- R6: In mode 2 the table result for the live index is captured on each enabled rising clock edge, and the captured bit drives the output. A change at the inputs reaches the output at the next edge.
- R7: In mode 3 the output is 1 while t0 is high and 0 while t0 is low and t1 is high; if both are high, set wins and the output is 1. With both low, the output keeps the state captured at the last enabled edge. The truth table has no effect in this mode.
- R8: While `enable` is low, the three internal flip-flops keep their values across clock edges. The combinational path of mode 0 keeps following its inputs.
- R9: With all three selectors set to the same code and the table set to 8'b0000_0001, the output is the inverse of the selected signal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock, rising edge |
| rst | input | 1 | Synchronous fabric reset, active high |
| enable | input | 1 | Lets the internal flip-flops update when high |
| mode | input | 2 | 0 combinational, 1 sampled third trigger, 2 registered, 3 set/clear |
| table_bits | input | 8 | Truth table, bit n is the result for index n |
| sel_tr0 | input | 4 | Source code for trigger 0 |
| sel_tr1 | input | 4 | Source code for trigger 1 |
| sel_tr2 | input | 4 | Source code for trigger 2 |
| cell_fb | input | 8 | Outputs of the eight cells of the array |
| chip_sig | input | 8 | Chip-side signals of the whole port |
| pad_sig | input | 8 | Pad-side signals of the whole port |
| cell_out | output | 1 | Cell result |

## Verification
The combinational function is swept over all eight index values with two unrelated tables. This separates a correct bit order from a reversed or shifted index. The unused feedback bits are held at a busy pattern to expose selection of the wrong line. The half mapping is tried by pointing all three selectors at each of the eight port codes, with chip and pad patterns whose lower and upper nibbles differ in every position, on a low-half and a high-half instance side by side. That pattern tells apart a wrong half, a swapped chip and pad group, and a wrong offset. The clocked modes are probed just before and just after an edge. This shows which trigger is delayed, whether the registered result lags by exactly one edge, that set wins over clear, that the table is ignored in set/clear mode, and that a disabled cell holds its state while mode 0 still follows its inputs.

// File: rtl/lut3_pkg.sv
`timescale 1ns/1ps
package lut3_pkg;

  typedef enum logic [1:0] {
    MODE_COMB        = 2'd0,
    MODE_TR2_SAMPLED = 2'd1,
    MODE_REGISTERED  = 2'd2,
    MODE_SET_CLEAR   = 2'd3
  } cell_mode_e;

  localparam int unsigned TRIG_COUNT = 3;
  localparam int unsigned TABLE_W    = 1 << TRIG_COUNT;

  // Truth-table lookup: index n returns bit n.
  function automatic logic table_pick(input logic [TABLE_W-1:0] tbl,
                                      input logic [TRIG_COUNT-1:0] idx);
    return tbl[idx];
  endfunction

  // Set/clear resolution with set priority; otherwise keep the held bit.
  function automatic logic sr_resolve(input logic set_in, input logic clr_in,
                                      input logic held);
    if (set_in) return 1'b1;
    if (clr_in) return 1'b0;
    return held;
  endfunction

endpackage

// File: rtl/lut3_src_mux.sv
`timescale 1ns/1ps
module lut3_src_mux #(
  parameter int NUM_CELLS = 8,
  parameter int HALF      = 0,
  localparam int IDX_W    = $clog2(NUM_CELLS),
  localparam int SEL_W    = IDX_W + 1
) (
  input  logic [SEL_W-1:0]     sel,
  input  logic [NUM_CELLS-1:0] cell_fb,
  input  logic [NUM_CELLS-1:0] chip_sig,
  input  logic [NUM_CELLS-1:0] pad_sig,
  output logic                 src
);
  localparam int GRP_W = IDX_W - 1;

  logic             is_port;
  logic             is_pad;
  logic [IDX_W-1:0] fb_idx;
  logic [IDX_W-1:0] port_idx;

  assign is_port = sel[SEL_W-1];
  assign is_pad  = sel[SEL_W-2];
  assign fb_idx  = sel[IDX_W-1:0];

  // The half parameter picks which group of port lines the local code reaches.
  generate
    if (HALF != 0) begin : g_upper
      assign port_idx = {1'b1, sel[GRP_W-1:0]};
    end else begin : g_lower
      assign port_idx = {1'b0, sel[GRP_W-1:0]};
    end
  endgenerate

  always_comb begin
    if (!is_port)    src = cell_fb[fb_idx];
    else if (is_pad) src = pad_sig[port_idx];
    else             src = chip_sig[port_idx];
  end

endmodule

// File: rtl/lut3_state.sv
`timescale 1ns/1ps
module lut3_state (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic tr2_in,
  input  logic comb_bit,
  input  logic sr_next,
  output logic tr2_q,
  output logic out_q,
  output logic sr_q
);
  // All three flops update in every mode so a mode change never sees stale state.
  always_ff @(posedge clk) begin
    if (rst) begin
      tr2_q <= 1'b0;
      out_q <= 1'b0;
      sr_q  <= 1'b0;
    end else if (enable) begin
      tr2_q <= tr2_in;
      out_q <= comb_bit;
      sr_q  <= sr_next;
    end
  end

endmodule

// File: rtl/lut3_cell.sv
`timescale 1ns/1ps
module lut3_cell #(
  parameter int NUM_CELLS = 8,
  parameter int HALF      = 0,
  localparam int IDX_W    = $clog2(NUM_CELLS),
  localparam int SEL_W    = IDX_W + 1,
  localparam int TBL_W    = lut3_pkg::TABLE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic [1:0]           mode,
  input  logic [TBL_W-1:0]     table_bits,
  input  logic [SEL_W-1:0]     sel_tr0,
  input  logic [SEL_W-1:0]     sel_tr1,
  input  logic [SEL_W-1:0]     sel_tr2,
  input  logic [NUM_CELLS-1:0] cell_fb,
  input  logic [NUM_CELLS-1:0] chip_sig,
  input  logic [NUM_CELLS-1:0] pad_sig,
  output logic                 cell_out
);
  import lut3_pkg::*;

  localparam int NTRIG = TRIG_COUNT;

  logic [SEL_W-1:0] sel_arr [NTRIG];
  logic [NTRIG-1:0] trig;
  logic [NTRIG-1:0] idx_held;
  logic             comb_bit;
  logic             held_bit;
  logic             sr_next;
  logic             upd_en;
  logic             tr2_q;
  logic             out_q;
  logic             sr_q;
  cell_mode_e       mode_e;

  assign sel_arr[0] = sel_tr0;
  assign sel_arr[1] = sel_tr1;
  assign sel_arr[2] = sel_tr2;

  generate
    for (genvar t = 0; t < NTRIG; t++) begin : g_trig
      lut3_src_mux #(.NUM_CELLS(NUM_CELLS), .HALF(HALF)) u_mux (
        .sel      (sel_arr[t]),
        .cell_fb  (cell_fb),
        .chip_sig (chip_sig),
        .pad_sig  (pad_sig),
        .src      (trig[t])
      );
    end
  endgenerate

  assign idx_held = {tr2_q, trig[1:0]};
  assign comb_bit = table_pick(table_bits, trig);
  assign held_bit = table_pick(table_bits, idx_held);
  assign sr_next  = sr_resolve(trig[0], trig[1], sr_q);
  assign upd_en   = enable & ~rst;
  assign mode_e   = cell_mode_e'(mode);

  lut3_state u_state (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .tr2_in   (trig[2]),
    .comb_bit (comb_bit),
    .sr_next  (sr_next),
    .tr2_q    (tr2_q),
    .out_q    (out_q),
    .sr_q     (sr_q)
  );

  always_comb begin
    unique case (mode_e)
      MODE_COMB:        cell_out = comb_bit;
      MODE_TR2_SAMPLED: cell_out = held_bit;
      MODE_REGISTERED:  cell_out = out_q;
      MODE_SET_CLEAR:   cell_out = sr_next;
      default:          cell_out = comb_bit;
    endcase
  end

endmodule

// File: rtl/lut3_cell_chk.sv
`timescale 1ns/1ps
module lut3_cell_chk #(
  parameter int NUM_CELLS = 8,
  parameter int IDX_W     = 3,
  parameter int SEL_W     = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 enable,
  input logic [1:0]           mode,
  input logic [7:0]           table_bits,
  input logic [SEL_W-1:0]     sel_tr0,
  input logic [NUM_CELLS-1:0] cell_fb,
  input logic [2:0]           trig,
  input logic                 tr2_q,
  input logic                 out_q,
  input logic                 sr_q,
  input logic                 cell_out
);

  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!tr2_q && !out_q && !sr_q));

  a_r2_comb_lookup: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |-> (cell_out == table_bits[trig]));

  a_r3_feedback_pick: assert property (@(posedge clk) disable iff (rst)
    !sel_tr0[SEL_W-1] |-> (trig[0] == cell_fb[sel_tr0[IDX_W-1:0]]));

  a_r5_sampled_tr2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && $past(enable) && !$past(rst))
      |-> (cell_out == table_bits[{$past(trig[2]), trig[1:0]}]));

  a_r6_one_edge_lag: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && $past(enable) && !$past(rst))
      |-> (cell_out == $past(table_bits[trig])));

  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && trig[0]) |-> cell_out);

  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && !trig[0] && trig[1]) |-> !cell_out);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3 && !trig[0] && !trig[1]) |-> (cell_out == sr_q));

  a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
    (!$past(enable) && !$past(rst)) |-> ($stable(tr2_q) && $stable(out_q) && $stable(sr_q)));

endmodule

bind lut3_cell lut3_cell_chk #(.NUM_CELLS(NUM_CELLS), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .mode       (mode),
  .table_bits (table_bits),
  .sel_tr0    (sel_tr0),
  .cell_fb    (cell_fb),
  .trig       (trig),
  .tr2_q      (tr2_q),
  .out_q      (out_q),
  .sr_q       (sr_q),
  .cell_out   (cell_out)
);

// File: tb/test_lut3_cell.sv
`timescale 1ns/1ps
module test_lut3_cell;
  logic       clk = 1'b0;
  logic       rst, enable;
  logic [1:0] mode;
  logic [7:0] tbl;
  logic [3:0] s0, s1, s2;
  logic [7:0] fb, chip, pad;
  logic       out_lo, out_hi;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  lut3_cell #(.NUM_CELLS(8), .HALF(0)) i_lut3_cell (
    .clk(clk), .rst(rst), .enable(enable), .mode(mode), .table_bits(tbl),
    .sel_tr0(s0), .sel_tr1(s1), .sel_tr2(s2), .cell_fb(fb),
    .chip_sig(chip), .pad_sig(pad), .cell_out(out_lo));

  lut3_cell #(.NUM_CELLS(8), .HALF(1)) i_lut3_cell_hi (
    .clk(clk), .rst(rst), .enable(enable), .mode(mode), .table_bits(tbl),
    .sel_tr0(s0), .sel_tr1(s1), .sel_tr2(s2), .cell_fb(fb),
    .chip_sig(chip), .pad_sig(pad), .cell_out(out_hi));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic sels(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
    s0 = a; s1 = b; s2 = c;
  endtask

  task automatic t_reset;
    rst = 1'b1; enable = 1'b1; mode = 2'd2; tbl = 8'hFF; fb = 8'hFF;
    sels(4'd0, 4'd1, 4'd2);
    tick; tick;
    chk("R1 registered output after reset", out_lo, 1'b0);
    mode = 2'd1; tbl = 8'hF0; #1;
    chk("R1 sampled tr2 after reset", out_lo, 1'b0);
    mode = 2'd3; fb = 8'h00; #1;
    chk("R1 set/clear state after reset", out_lo, 1'b0);
    mode = 2'd1; fb = 8'hFF; rst = 1'b0;
    tick;
    chk("R1 sampled tr2 after release", out_lo, 1'b1);
  endtask

  task automatic t_comb;
    logic [7:0] tabs [2];
    tabs[0] = 8'hB4; tabs[1] = 8'h2D;
    mode = 2'd0; sels(4'd0, 4'd1, 4'd2);
    for (int t = 0; t < 2; t++) begin
      tbl = tabs[t];
      for (int p = 0; p < 8; p++) begin
        fb = {5'b11010, 3'(p)}; #1;
        chk("R2 combinational index", out_lo, tbl[3'(p)]);
      end
    end
    tbl = 8'hB4; sels(4'd5, 4'd6, 4'd7);
    for (int p = 0; p < 8; p++) begin
      fb = {3'(p), 5'b01011}; #1;
      chk("R3 upper feedback codes", out_lo, tbl[3'(p)]);
    end
  endtask

  task automatic t_half;
    logic [7:0] cp [2];
    logic [7:0] pp [2];
    cp[0] = 8'h5A; pp[0] = 8'hC3; cp[1] = 8'hA5; pp[1] = 8'h3C;
    mode = 2'd0; tbl = 8'h80; fb = 8'h00;
    for (int v = 0; v < 2; v++) begin
      chip = cp[v]; pad = pp[v];
      for (int k = 0; k < 8; k++) begin
        logic el, eh;
        sels(4'(8 + k), 4'(8 + k), 4'(8 + k)); #1;
        el = (k < 4) ? chip[3'(k)] : pad[3'(k - 4)];
        eh = (k < 4) ? chip[3'(k + 4)] : pad[3'(k)];
        chk("R4 lower half port pick", out_lo, el);
        chk("R4 upper half port pick", out_hi, eh);
      end
    end
  endtask

  task automatic t_inv;
    mode = 2'd0; tbl = 8'b0000_0001; sels(4'd3, 4'd3, 4'd3);
    fb = 8'h08; #1;
    chk("R9 inverter high in", out_lo, 1'b0);
    chk("R9 inverter high in (upper)", out_hi, 1'b0);
    fb = 8'hF7; #1;
    chk("R9 inverter low in", out_lo, 1'b1);
    chip = 8'hFF; sels(4'd9, 4'd9, 4'd9); #1;
    chk("R9 inverter on chip line", out_lo, 1'b0);
  endtask

  task automatic t_mode1;
    mode = 2'd1; tbl = 8'hF0; sels(4'd0, 4'd1, 4'd2); fb = 8'h00;
    tick;
    fb = 8'h04; #1;
    chk("R5 tr2 rise not yet seen", out_lo, 1'b0);
    tick;
    chk("R5 tr2 rise after edge", out_lo, 1'b1);
    fb = 8'h00; #1;
    chk("R5 tr2 fall not yet seen", out_lo, 1'b1);
    tick;
    chk("R5 tr2 fall after edge", out_lo, 1'b0);
    tbl = 8'hAA; fb = 8'h01; #1;
    chk("R5 tr0 passes at once", out_lo, 1'b1);
    fb = 8'h00; #1;
    chk("R5 tr0 release at once", out_lo, 1'b0);
  endtask

  task automatic t_mode2;
    mode = 2'd2; tbl = 8'h96; sels(4'd0, 4'd1, 4'd2); fb = 8'h00;
    tick;
    chk("R6 registered start", out_lo, 1'b0);
    fb = 8'h01; #1;
    chk("R6 before edge", out_lo, 1'b0);
    tick;
    chk("R6 after edge", out_lo, 1'b1);
    fb = 8'h03; #1;
    chk("R6 before second edge", out_lo, 1'b1);
    tick;
    chk("R6 after second edge", out_lo, 1'b0);
    fb = 8'h07; tick;
    chk("R6 three ones", out_lo, 1'b1);
  endtask

  task automatic t_mode3;
    mode = 2'd3; tbl = 8'h00; sels(4'd0, 4'd1, 4'd2);
    fb = 8'h02; #1;
    chk("R7 clear", out_lo, 1'b0);
    tick; fb = 8'h00; #1;
    chk("R7 hold low", out_lo, 1'b0);
    fb = 8'h01; #1;
    chk("R7 set at once", out_lo, 1'b1);
    tick; fb = 8'h00; #1;
    chk("R7 hold high", out_lo, 1'b1);
    tbl = 8'hFF; fb = 8'h02; #1;
    chk("R7 table ignored on clear", out_lo, 1'b0);
    tick; fb = 8'h04; #1;
    chk("R7 tr2 alone holds low", out_lo, 1'b0);
    fb = 8'h03; #1;
    chk("R7 set wins over clear", out_lo, 1'b1);
    tick; fb = 8'h00; #1;
    chk("R7 hold after both", out_lo, 1'b1);
  endtask

  task automatic t_enable;
    mode = 2'd2; tbl = 8'h96; sels(4'd0, 4'd1, 4'd2); enable = 1'b1; fb = 8'h01;
    tick;
    chk("R8 enabled capture", out_lo, 1'b1);
    enable = 1'b0; fb = 8'h03;
    tick; tick; tick;
    chk("R8 registered output frozen", out_lo, 1'b1);
    mode = 2'd0; #1;
    chk("R8 combinational still live", out_lo, 1'b0);
    mode = 2'd2; enable = 1'b1;
    tick;
    chk("R8 resumes after enable", out_lo, 1'b0);
    mode = 2'd3; fb = 8'h01;
    tick;
    enable = 1'b0; fb = 8'h02; #1;
    chk("R8 clear still drives output", out_lo, 1'b0);
    tick; fb = 8'h00; #1;
    chk("R8 set/clear state frozen", out_lo, 1'b1);
    enable = 1'b1;
  endtask

  initial begin
    rst = 1'b1; enable = 1'b1; mode = 2'd0; tbl = 8'h00;
    s0 = 4'd0; s1 = 4'd0; s2 = 4'd0;
    fb = 8'h00; chip = 8'h00; pad = 8'h00;
    t_reset;
    t_comb;
    t_half;
    t_inv;
    t_mode1;
    t_mode2;
    t_mode3;
    t_enable;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule